// File: doc/BRIEF.md
# Protected Page-Write Sequencer for a Serial EEPROM

This block sits behind the command decoder of a serial EEPROM. The decoder turns the serial bit stream into opcode strobes, address words and completed data bytes. This block turns them into qualified, self-timed writes to a byte-wide array. It owns three pieces of state: the write-enable latch, the two-bit protected-zone field of the status byte, and a small page buffer. A page-write frame fills the buffer. When chip select deasserts, the block decides whether the frame earned a write cycle. It then counts out a fixed busy period and, during that period, commits every buffered byte that lies outside the protected zone.

A write cycle needs four things at the moment chip select rises: the latch must be set, the write-protect input must be high, at least one whole byte must have been received, and no partial byte may be in flight. If write-protect drops at any point while the frame is still open, that frame is spoiled. After the cycle has started, write-protect no longer matters. While a cycle runs, all commands are dropped and only the status output remains meaningful. When the cycle ends, the latch clears.

Top module: `eewp_seq`

## Requirements
- R1: After reset the status byte reads 0x00, `busy` is low and `mem_we` is low.
- R2: Status byte layout: bit 0 is busy, bit 1 is the write-enable latch, bits 3:2 are the protected-zone field, and bits 7:4 read 0. Opcode 1 sets the latch and opcode 2 clears it. The opcodes used are 1 set latch, 2 clear latch, 3 read status, 4 write status and 5 page write; every other value has no effect.
- R3: A page write or status write whose frame ends with the latch clear starts no cycle and changes no stored state.
- R4: If `wp_n` is low in any cycle while a write frame is open, or at the moment chip select rises, no cycle starts.
- R5: Once `busy` is high, `wp_n` has no effect; the cycle runs to completion and commits its bytes.
- R6: In a page write, the low 3 address bits start at the command address and increment after each byte, wrapping within the page while the upper bits stay fixed. A later byte to the same location replaces an earlier one.
- R7: A write frame that ends with `byte_aligned` low, or with no complete data byte, starts no cycle and leaves the latch unchanged.
- R8: `busy` rises in the cycle after chip select rises and stays high for exactly WRITE_CYCLES cycles. All array commits fall within the first 8 of those cycles.
- R9: Zone field 0 protects nothing, 1 protects the top quarter of the address space, 2 the top half and 3 everything. Protected bytes are never committed, but the cycle still runs.
- R10: The write-enable latch reads 0 once a cycle completes.
- R11: While `busy` is high, every command and data byte is ignored, including a clear-latch command and a status write. The status byte keeps reporting.
- R12: A status write loads bits 3:2 of its first data byte into the zone field when its cycle starts. Further bytes in the same frame are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select from the serial front end, active low |
| cmd_valid | input | 1 | Opcode strobe |
| cmd_op | input | 3 | Decoded opcode |
| cmd_addr | input | AW | Start address for a page write |
| data_valid | input | 1 | A complete data byte has been received |
| data_byte | input | 8 | Received data byte |
| byte_aligned | input | 1 | Serial bit counter is at a byte boundary |
| wp_n | input | 1 | Hardware write protect, active low |
| status | output | 8 | Status byte |
| busy | output | 1 | Internal write cycle in progress |
| mem_we | output | 1 | Array byte write strobe |
| mem_addr | output | AW | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The bench builds the block with AW=5, which gives a 32-byte array of four pages, with 3-bit page offsets and WRITE_CYCLES=20. At that size every protected-zone setting can be crossed with every page, and the whole array can be compared against an arithmetic model after each cycle. The byte counts per frame run from 3 to 12, so both partial pages and wrapped pages occur in every zone setting. The short cycle length makes exact busy-length counts cheap. It also leaves room to place write-protect changes and commands inside a running cycle.

// File: rtl/eewp_pkg.sv
package eewp_pkg;

    typedef enum logic [2:0] {
        OP_NONE      = 3'd0,
        OP_LATCH_SET = 3'd1,
        OP_LATCH_CLR = 3'd2,
        OP_STAT_RD   = 3'd3,
        OP_STAT_WR   = 3'd4,
        OP_PAGE_WR   = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_PAGE,
        SQ_STAT,
        SQ_SKIP
    } seq_e;

endpackage

// File: rtl/eewp_region.sv
module eewp_region #(
    parameter int AW = 9
) (
    input  logic [AW-1:0] addr,
    input  logic [1:0]    zone,
    output logic          blocked
);
    // zone 1: top quarter, zone 2: top half, zone 3: everything
    always_comb begin
        case (zone)
            2'd0:    blocked = 1'b0;
            2'd1:    blocked = &addr[AW-1:AW-2];
            2'd2:    blocked = addr[AW-1];
            default: blocked = 1'b1;
        endcase
    end
endmodule

// File: rtl/eewp_pagebuf.sv
module eewp_pagebuf #(
    parameter int PW = 3,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [PW-1:0] rd_idx,
    output logic [DW-1:0] rd_data,
    output logic          rd_vld
);
    localparam int ENTRIES = 1 << PW;

    logic [ENTRIES*DW-1:0] dat_flat;
    logic [ENTRIES-1:0]    vld_vec;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        logic [DW-1:0] dat_q;
        logic          vld_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dat_q <= '0;
                vld_q <= 1'b0;
            end else if (clr) begin
                vld_q <= 1'b0;
            end else if (wr_en && (wr_idx == PW'(i))) begin
                dat_q <= wr_data;
                vld_q <= 1'b1;
            end
        end
        assign dat_flat[i*DW +: DW] = dat_q;
        assign vld_vec[i]           = vld_q;
    end

    assign rd_data = dat_flat[rd_idx*DW +: DW];
    assign rd_vld  = vld_vec[rd_idx];
endmodule

// File: rtl/eewp_seq.sv
module eewp_seq
    import eewp_pkg::*;
#(
    parameter int AW           = 9,
    parameter int PW           = 3,
    parameter int WRITE_CYCLES = 50000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic          data_valid,
    input  logic [7:0]    data_byte,
    input  logic          byte_aligned,
    input  logic          wp_n,
    output logic [7:0]    status,
    output logic          busy,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata
);
    localparam int PAGE = 1 << PW;
    localparam int TW   = $clog2(WRITE_CYCLES + 1);

    typedef struct packed {
        seq_e          seq;
        logic          wel;
        logic [1:0]    zone;
        logic          busy;
        logic          pg;
        logic [TW-1:0] tmr;
        logic [AW-1:0] base;
        logic [PW-1:0] ptr;
        logic          got;
        logic          spoil;
        logic [1:0]    zone_pend;
    } st_t;

    st_t st_d, st_q;

    logic          buf_wr, buf_clr;
    logic [7:0]    buf_rd;
    logic          buf_vld;
    logic          zone_hit;
    logic          in_window;
    logic [AW-1:0] commit_addr;

    assign commit_addr = {st_q.base[AW-1:PW], st_q.tmr[PW-1:0]};
    assign in_window   = st_q.busy && st_q.pg && (st_q.tmr < TW'(PAGE));

    eewp_pagebuf #(.PW(PW), .DW(8)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (buf_clr),
        .wr_en   (buf_wr),
        .wr_idx  (st_q.ptr),
        .wr_data (data_byte),
        .rd_idx  (st_q.tmr[PW-1:0]),
        .rd_data (buf_rd),
        .rd_vld  (buf_vld)
    );

    eewp_region #(.AW(AW)) u_region (
        .addr    (commit_addr),
        .zone    (st_q.zone),
        .blocked (zone_hit)
    );

    always_comb begin
        st_d    = st_q;
        buf_wr  = 1'b0;
        buf_clr = 1'b0;
        if (st_q.busy) begin
            // the frame in flight, if any, is dropped whole
            st_d.seq = cs_n ? SQ_IDLE : SQ_SKIP;
            st_d.tmr = st_q.tmr + 1'b1;
            if (st_q.tmr == TW'(WRITE_CYCLES - 1)) begin
                st_d.busy = 1'b0;
                st_d.wel  = 1'b0;
                st_d.tmr  = '0;
                buf_clr   = 1'b1;
            end
        end else begin
            case (st_q.seq)
                SQ_IDLE: begin
                    if (!cs_n && cmd_valid) begin
                        st_d.seq = SQ_SKIP;
                        case (op_e'(cmd_op))
                            OP_LATCH_SET: st_d.wel = 1'b1;
                            OP_LATCH_CLR: st_d.wel = 1'b0;
                            OP_STAT_WR: begin
                                st_d.seq   = SQ_STAT;
                                st_d.got   = 1'b0;
                                st_d.spoil = !wp_n;
                            end
                            OP_PAGE_WR: begin
                                st_d.seq   = SQ_PAGE;
                                st_d.base  = cmd_addr;
                                st_d.ptr   = cmd_addr[PW-1:0];
                                st_d.got   = 1'b0;
                                st_d.spoil = !wp_n;
                                buf_clr    = 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end
                SQ_PAGE: begin
                    if (cs_n) begin
                        st_d.seq = SQ_IDLE;
                        if (st_q.got && byte_aligned && !st_q.spoil && st_q.wel && wp_n) begin
                            st_d.busy = 1'b1;
                            st_d.pg   = 1'b1;
                            st_d.tmr  = '0;
                        end
                    end else begin
                        if (!wp_n) st_d.spoil = 1'b1;
                        if (data_valid) begin
                            buf_wr   = 1'b1;
                            st_d.ptr = st_q.ptr + 1'b1;
                            st_d.got = 1'b1;
                        end
                    end
                end
                SQ_STAT: begin
                    if (cs_n) begin
                        st_d.seq = SQ_IDLE;
                        if (st_q.got && byte_aligned && !st_q.spoil && st_q.wel && wp_n) begin
                            st_d.busy = 1'b1;
                            st_d.pg   = 1'b0;
                            st_d.tmr  = '0;
                            st_d.zone = st_q.zone_pend;
                        end
                    end else begin
                        if (!wp_n) st_d.spoil = 1'b1;
                        if (data_valid && !st_q.got) begin
                            st_d.zone_pend = data_byte[3:2];
                            st_d.got       = 1'b1;
                        end
                    end
                end
                default: begin
                    if (cs_n) st_d.seq = SQ_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{seq: SQ_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign status    = {4'b0000, st_q.zone, st_q.wel, st_q.busy};
    assign busy      = st_q.busy;
    assign mem_we    = in_window && buf_vld && !zone_hit;
    assign mem_addr  = commit_addr;
    assign mem_wdata = buf_rd;
endmodule

// File: rtl/eewp_seq_chk.sv
module eewp_seq_chk #(
    parameter int AW           = 9,
    parameter int PW           = 3,
    parameter int WRITE_CYCLES = 50000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wp_n,
    input logic [7:0]    status,
    input logic          busy,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr
);
    localparam int DEPTH = 1 << AW;
    localparam int CW    = $clog2(WRITE_CYCLES + 2);

    logic [CW-1:0] run_cnt;
    int            open_lim;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_cnt <= '0;
        else if (busy) run_cnt <= run_cnt + 1'b1;
        else           run_cnt <= '0;
    end

    // first protected address for the current zone setting
    always_comb begin
        case (status[3:2])
            2'd0:    open_lim = DEPTH;
            2'd1:    open_lim = DEPTH - DEPTH / 4;
            2'd2:    open_lim = DEPTH / 2;
            default: open_lim = 0;
        endcase
    end

    p_we_in_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    p_commit_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (run_cnt < CW'(1 << PW)));

    p_busy_length_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_cnt == CW'(WRITE_CYCLES)));

    p_zone_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (int'(mem_addr) < open_lim));

    p_latch_cleared_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !status[1]);

    p_launch_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(status[1]));

    p_launch_pin_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wp_n));

    p_zone_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(status[3:2]));
endmodule

bind eewp_seq eewp_seq_chk #(.AW(AW), .PW(PW), .WRITE_CYCLES(WRITE_CYCLES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wp_n     (wp_n),
    .status   (status),
    .busy     (busy),
    .mem_we   (mem_we),
    .mem_addr (mem_addr)
);

// File: tb/eewp_seq_tb.sv
module eewp_seq_tb;
    localparam int AW = 5;
    localparam int PW = 3;
    localparam int WC = 20;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = 3'd0;
    logic [AW-1:0] cmd_addr = '0;
    logic          data_valid = 1'b0;
    logic [7:0]    data_byte = 8'h00;
    logic          byte_aligned = 1'b1;
    logic          wp_n = 1'b1;
    logic [7:0]    status;
    logic          busy;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    int cur_zone = 0;
    logic [7:0] got_mem [DEPTH];
    logic [7:0] exp_mem [DEPTH];

    always #5 clk = ~clk;

    eewp_seq #(.AW(AW), .PW(PW), .WRITE_CYCLES(WC)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .data_valid(data_valid),
        .data_byte(data_byte), .byte_aligned(byte_aligned), .wp_n(wp_n),
        .status(status), .busy(busy), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    always @(negedge clk) begin
        if (rst_n && mem_we) got_mem[mem_addr] <= mem_wdata;
    end

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic frame_open();
        cs_n = 1'b0;
        tick();
    endtask

    task automatic issue(input logic [2:0] op, input logic [AW-1:0] a);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a;
        tick();
        cmd_valid = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        data_valid = 1'b1; data_byte = b;
        tick();
        data_valid = 1'b0;
    endtask

    task automatic frame_close(input bit aligned);
        byte_aligned = aligned; cs_n = 1'b1;
        tick();
        byte_aligned = 1'b1;
    endtask

    task automatic simple_cmd(input logic [2:0] op);
        frame_open(); issue(op, '0); frame_close(1'b1);
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 1000) begin n++; tick(); end
        tick();
    endtask

    function automatic bit zone_blocks(input int z, input int a);
        if (z == 0) return 1'b0;
        if (z == 1) return a >= (DEPTH * 3) / 4;
        if (z == 2) return a >= DEPTH / 2;
        return 1'b1;
    endfunction

    task automatic compare_mem(input string tag);
        int bad = 0;
        for (int i = 0; i < DEPTH; i++) if (got_mem[i] !== exp_mem[i]) bad++;
        check_eq(tag, bad, 0);
    endtask

    // send a page-write frame; model its effect if a launch is expected
    task automatic page_frame(input int start, input int n, input int seed,
                              input bit aligned, input bit launch);
        frame_open();
        issue(3'd5, AW'(start));
        for (int k = 0; k < n; k++) begin
            int a = (start & ~(8 - 1)) | ((start + k) & 7);
            push(8'(seed + k));
            if (launch && !zone_blocks(cur_zone, a)) exp_mem[a] = 8'(seed + k);
        end
        frame_close(aligned);
    endtask

    task automatic set_zone(input int z);
        int n;
        simple_cmd(3'd1);
        frame_open(); issue(3'd4, '0); push(8'(z << 2)); push(8'hFF); frame_close(1'b1);
        wait_idle(n);
        cur_zone = z;
        check_eq("R12 zone loaded, extra byte ignored", int'(status), z << 2);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n;
        for (int i = 0; i < DEPTH; i++) begin got_mem[i] = 8'h00; exp_mem[i] = 8'h00; end
        tick(); tick();
        check_eq("R1 status in reset", int'(status), 0);
        rst_n = 1'b1;
        tick();
        check_eq("R1 status after reset", int'(status), 0);
        check_eq("R1 busy after reset", int'(busy), 0);
        check_eq("R1 mem_we after reset", int'(mem_we), 0);

        // R2: latch set / clear, layout
        simple_cmd(3'd1);
        check_eq("R2 latch set", int'(status), 8'h02);
        simple_cmd(3'd6);
        check_eq("R2 unknown opcode no effect", int'(status), 8'h02);
        simple_cmd(3'd2);
        check_eq("R2 latch cleared", int'(status), 8'h00);

        // R3: no latch, no write
        page_frame(0, 8, 8'h40, 1'b1, 1'b0);
        check_eq("R3 no cycle without latch", int'(busy), 0);
        frame_open(); issue(3'd4, '0); push(8'h0C); frame_close(1'b1);
        check_eq("R3 status write without latch", int'(status), 0);

        // R6/R8/R9/R10: every zone against every page
        for (int z = 0; z < 4; z++) begin
            set_zone(z);
            for (int pg = 0; pg < DEPTH / 8; pg++) begin
                int nb = 3 + (z * 4 + pg) % 10;
                int st = pg * 8 + (pg * 3 + z) % 8;
                simple_cmd(3'd1);
                check_eq("R2 latch with zone", int'(status), (z << 2) | 2);
                page_frame(st, nb, z * 64 + pg * 16 + 1, 1'b1, 1'b1);
                wait_idle(n);
                check_eq("R8 busy length", n, WC);
                check_eq("R10 latch cleared after cycle", int'(status), z << 2);
                compare_mem("R9/R6 array contents");
            end
        end

        // R7: partial byte, and no data byte
        set_zone(0);
        simple_cmd(3'd1);
        page_frame(2, 2, 8'hA0, 1'b0, 1'b0);
        check_eq("R7 partial byte no cycle", int'(status), 8'h02);
        page_frame(2, 0, 8'hA0, 1'b1, 1'b0);
        check_eq("R7 empty frame no cycle", int'(status), 8'h02);

        // R4: pin low mid-frame, and low at the close
        frame_open(); issue(3'd5, 5'd9); push(8'h11);
        wp_n = 1'b0; tick(); wp_n = 1'b1;
        push(8'h12); frame_close(1'b1);
        check_eq("R4 pin pulse spoils frame", int'(status), 8'h02);
        frame_open(); issue(3'd5, 5'd9); push(8'h13);
        wp_n = 1'b0; frame_close(1'b1); wp_n = 1'b1;
        check_eq("R4 pin low at close", int'(status), 8'h02);
        tick(); tick();
        compare_mem("R4 array untouched");

        // R5: pin low after launch
        page_frame(12, 4, 8'hC0, 1'b1, 1'b1);
        wp_n = 1'b0;
        wait_idle(n);
        wp_n = 1'b1;
        check_eq("R5 cycle length with pin low", n, WC);
        compare_mem("R5 bytes committed");

        // R11: commands during a cycle
        simple_cmd(3'd1);
        page_frame(20, 3, 8'hD0, 1'b1, 1'b1);
        simple_cmd(3'd2);
        check_eq("R11 clear-latch ignored while busy", int'(status), 8'h03);
        frame_open(); issue(3'd4, '0); push(8'h0C); frame_close(1'b1);
        wait_idle(n);
        check_eq("R11 zone unchanged after busy", int'(status), 0);
        compare_mem("R11 array after cycle");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule